// File: doc/BRIEF.md
# Multi-Drive Seek and Attention Sequencer

This block tracks the head positioners of a set of disk drives that share one controller. Each drive unit holds its current cylinder and a stored function code. The controller issues a command with a one-cycle start strobe. The strobe carries a unit number, a function code and a target cylinder. A seek or recalibrate command runs in two phases. The first phase occupies the shared controller for a short fixed time. At its end the controller is free again, the unit's cylinder takes the target value, and the unit's stored function changes to a second-phase code. The unit then finishes the move on its own timer and posts an attention bit.

Each unit has its own countdown, so any number of units can move at once. The length of the second phase is the cylinder distance times a programmable per-cylinder delay, with a floor of two cycles. While a unit is moving it reports seeking, which also means not ready. A unit that is at rest on a cylinder beyond the last valid one reports seek-incomplete. Data transfer commands are not handled here, and their codes are ignored.

Top module: `drive_seek_seq`

## Requirements
- R1: When the controller is not busy and the addressed unit is not active, a start with function code idle (0), recalibrate (3) or seek (4) is accepted. Controller busy and the unit's active state are high from the next cycle.
- R2: Controller busy stays high for exactly 2 cycles after the accepting edge and then drops. This holds for every accepted function.
- R3: At the edge where busy drops, a seek sets the unit's cylinder to the start cylinder, and a recalibrate sets it to 0. The unit's stored function becomes the second-phase code 12 (the seek code 4 with flag value 8 added).
- R4: The unit's attention bit (bit u of the attention vector for unit u) sets max(2, |target − previous cylinder| × seek_delay) cycles after busy drops. At the same edge the unit leaves the active state.
- R5: A unit reports seeking from the cycle after acceptance until its attention sets. A unit running an idle function never reports seeking.
- R6: An idle function releases busy after 2 cycles and sets no attention bit.
- R7: A start is ignored, with no effect on busy, cylinder or seeking, in three cases: the controller is busy, the addressed unit is active, or the function code is not 0, 3 or 4.
- R8: Accepting a start on a unit clears that unit's attention bit on the accepting edge.
- R9: Units time their moves independently. A short seek on one unit can post attention while a longer seek on another unit is still in progress.
- R10: A unit that is not active and has a cylinder of NUM_CYL (203) or more reports seek-incomplete. An active unit never does.
- R11: Synchronous reset clears busy, every timer, every cylinder, every stored function and every attention bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle command strobe |
| start_unit | input | UNIT_W (3) | Addressed unit |
| start_func | input | 3 | Function code: 0 idle, 3 recalibrate, 4 seek |
| start_cyl | input | CYL_W (8) | Target cylinder for a seek |
| seek_delay | input | DELAY_W (8) | Cycles per cylinder of travel |
| ctrl_busy | output | 1 | Controller busy with a first phase |
| unit_active | output | NUM_UNITS (8) | Unit has a running timer |
| unit_seeking | output | NUM_UNITS (8) | Unit is moving (seeking and not ready) |
| unit_seek_inc | output | NUM_UNITS (8) | Unit at rest beyond the last cylinder |
| unit_attn | output | NUM_UNITS (8) | Per-unit attention flags |
| unit_cyl | output | NUM_UNITS*CYL_W (64) | Current cylinders, unit u at bits [u*CYL_W +: CYL_W] |

## Verification
The bench builds the block with its default parameters: eight units, an 8-bit cylinder field and 203 valid cylinders. With these values a seek to cylinder 210 is possible, which brings the seek-incomplete report within reach. It also makes three concurrent moves possible on separate units. The bench sets seek_delay to 1 or 3 so that moves of zero, short and long distance all finish in a few hundred cycles. A zero-distance seek checks the two-cycle floor on the second phase.

// File: rtl/drive_seek_pkg.sv
package drive_seek_pkg;
  localparam int FUNC_W  = 3;
  localparam int FCODE_W = 4;
  localparam int MIN_WAIT = 2;

  localparam logic [FUNC_W-1:0] FN_IDLE  = 3'd0;
  localparam logic [FUNC_W-1:0] FN_RECAL = 3'd3;
  localparam logic [FUNC_W-1:0] FN_SEEK  = 3'd4;
  localparam logic [FCODE_W-1:0] FC_PHASE2 = 4'd12;

  typedef enum logic [1:0] {PH_REST, PH_FIRST, PH_SECOND} phase_t;
endpackage

// File: rtl/seek_dist.sv
module seek_dist #(
  parameter int CYL_W   = 8,
  parameter int DELAY_W = 8,
  parameter int TIMER_W = CYL_W + DELAY_W
) (
  input  logic [CYL_W-1:0]   from_cyl,
  input  logic [CYL_W-1:0]   to_cyl,
  input  logic [DELAY_W-1:0] per_cyl,
  output logic [TIMER_W-1:0] wait_cycles
);
  logic [CYL_W-1:0]   span;
  logic [TIMER_W-1:0] prod;

  always_comb begin
    span = (to_cyl >= from_cyl) ? (to_cyl - from_cyl) : (from_cyl - to_cyl);
    prod = TIMER_W'(span) * TIMER_W'(per_cyl);
    wait_cycles = (prod < TIMER_W'(drive_seek_pkg::MIN_WAIT)) ?
                  TIMER_W'(drive_seek_pkg::MIN_WAIT) : prod;
  end
endmodule

// File: rtl/seek_unit.sv
module seek_unit
  import drive_seek_pkg::*;
#(
  parameter int CYL_W   = 8,
  parameter int DELAY_W = 8,
  parameter int TIMER_W = CYL_W + DELAY_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               launch,
  input  logic [FUNC_W-1:0]  func,
  input  logic [CYL_W-1:0]   target,
  input  logic [DELAY_W-1:0] per_cyl,
  output logic               active,
  output logic               in_first,
  output logic               seeking,
  output logic               first_end,
  output logic               move_end,
  output logic [CYL_W-1:0]   cyl
);
  phase_t              phase_q;
  logic [TIMER_W-1:0]  cnt_q;
  logic [FCODE_W-1:0]  fcode_q;
  logic [CYL_W-1:0]    tgt_q;
  logic [CYL_W-1:0]    cyl_q;
  logic [TIMER_W-1:0]  move_wait;
  logic                expire;

  seek_dist #(.CYL_W(CYL_W), .DELAY_W(DELAY_W), .TIMER_W(TIMER_W)) u_dist (
    .from_cyl   (cyl_q),
    .to_cyl     (tgt_q),
    .per_cyl    (per_cyl),
    .wait_cycles(move_wait)
  );

  assign active    = (phase_q != PH_REST);
  assign in_first  = (phase_q == PH_FIRST);
  assign expire    = active && (cnt_q == TIMER_W'(1));
  assign first_end = expire && (phase_q == PH_FIRST);
  assign move_end  = expire && (phase_q == PH_SECOND);
  assign cyl       = cyl_q;
  assign seeking   = active && ((fcode_q == {1'b0, FN_SEEK}) ||
                                (fcode_q == {1'b0, FN_RECAL}) ||
                                (fcode_q == FC_PHASE2));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_REST;
      cnt_q   <= '0;
      fcode_q <= '0;
      tgt_q   <= '0;
      cyl_q   <= '0;
    end else if (launch) begin
      phase_q <= PH_FIRST;
      cnt_q   <= TIMER_W'(MIN_WAIT);
      fcode_q <= {1'b0, func};
      tgt_q   <= (func == FN_RECAL) ? '0 : target;
    end else if (first_end) begin
      if (fcode_q == {1'b0, FN_IDLE}) begin
        phase_q <= PH_REST;
        cnt_q   <= '0;
      end else begin
        phase_q <= PH_SECOND;
        cnt_q   <= move_wait;
        cyl_q   <= tgt_q;
        fcode_q <= FC_PHASE2;
      end
    end else if (move_end) begin
      phase_q <= PH_REST;
      cnt_q   <= '0;
    end else if (active) begin
      cnt_q <= cnt_q - TIMER_W'(1);
    end
  end

  // R7: the controller never relaunches a unit that still runs a timer
  p_no_relaunch_r7: assert property (@(posedge clk) disable iff (rst)
    launch |-> !active);
  // R4: an active unit always has time left on its timer
  p_timer_live_r4: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt_q != '0));
  // R3: the cylinder moves only while the unit is active
  p_cyl_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !active |=> $stable(cyl_q));
endmodule

// File: rtl/drive_seek_seq.sv
module drive_seek_seq
  import drive_seek_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int CYL_W     = 8,
  parameter int NUM_CYL   = 203,
  parameter int DELAY_W   = 8,
  parameter int UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [UNIT_W-1:0]          start_unit,
  input  logic [FUNC_W-1:0]          start_func,
  input  logic [CYL_W-1:0]           start_cyl,
  input  logic [DELAY_W-1:0]         seek_delay,
  output logic                       ctrl_busy,
  output logic [NUM_UNITS-1:0]       unit_active,
  output logic [NUM_UNITS-1:0]       unit_seeking,
  output logic [NUM_UNITS-1:0]       unit_seek_inc,
  output logic [NUM_UNITS-1:0]       unit_attn,
  output logic [NUM_UNITS*CYL_W-1:0] unit_cyl
);
  localparam int TIMER_W = CYL_W + DELAY_W;

  logic                 busy_q;
  logic                 func_ok;
  logic                 accept;
  logic [NUM_UNITS-1:0] launch;
  logic [NUM_UNITS-1:0] first_end;
  logic [NUM_UNITS-1:0] move_end;
  logic [NUM_UNITS-1:0] in_first;
  logic [NUM_UNITS-1:0] attn_q;

  assign func_ok = (start_func == FN_IDLE) || (start_func == FN_SEEK) ||
                   (start_func == FN_RECAL);
  assign accept  = start && !busy_q && func_ok &&
                   (32'(start_unit) < NUM_UNITS) && !unit_active[start_unit];

  always_ff @(posedge clk) begin
    if (rst)               busy_q <= 1'b0;
    else if (accept)       busy_q <= 1'b1;
    else if (|first_end)   busy_q <= 1'b0;
  end

  assign ctrl_busy = busy_q;
  assign unit_attn = attn_q;

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
    logic [CYL_W-1:0] cyl_i;

    assign launch[i] = accept && (32'(start_unit) == i);

    seek_unit #(.CYL_W(CYL_W), .DELAY_W(DELAY_W), .TIMER_W(TIMER_W)) u_unit (
      .clk      (clk),
      .rst      (rst),
      .launch   (launch[i]),
      .func     (start_func),
      .target   (start_cyl),
      .per_cyl  (seek_delay),
      .active   (unit_active[i]),
      .in_first (in_first[i]),
      .seeking  (unit_seeking[i]),
      .first_end(first_end[i]),
      .move_end (move_end[i]),
      .cyl      (cyl_i)
    );

    assign unit_cyl[i*CYL_W +: CYL_W] = cyl_i;
    assign unit_seek_inc[i] = !unit_active[i] && (32'(cyl_i) >= NUM_CYL);

    always_ff @(posedge clk) begin
      if (rst)              attn_q[i] <= 1'b0;
      else if (launch[i])   attn_q[i] <= 1'b0;
      else if (move_end[i]) attn_q[i] <= 1'b1;
    end

    // R4: attention rises only as a running move finishes
    p_attn_on_finish_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(attn_q[i]) |-> ($past(unit_active[i]) && !unit_active[i]));
    // R10: no seek-incomplete report while the unit moves
    p_inc_at_rest_r10: assert property (@(posedge clk) disable iff (rst)
      unit_active[i] |-> !unit_seek_inc[i]);
  end

  // R2: busy marks exactly one unit in its first phase
  p_busy_one_first_r2: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> ($countones(in_first) == 1));
  // R1: a first phase never runs with the controller released
  p_first_needs_busy_r1: assert property (@(posedge clk) disable iff (rst)
    (|in_first) |-> busy_q);
endmodule

// File: tb/drive_seek_seq_bench.sv
module drive_seek_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NU = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [2:0]    start_unit = '0;
  logic [2:0]    start_func = '0;
  logic [CW-1:0] start_cyl = '0;
  logic [7:0]    seek_delay = 8'd3;
  logic          ctrl_busy;
  logic [NU-1:0] unit_active, unit_seeking, unit_seek_inc, unit_attn;
  logic [NU*CW-1:0] unit_cyl;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drive_seek_seq u_drive_seek_seq (
    .clk(clk), .rst(rst), .start(start), .start_unit(start_unit),
    .start_func(start_func), .start_cyl(start_cyl), .seek_delay(seek_delay),
    .ctrl_busy(ctrl_busy), .unit_active(unit_active), .unit_seeking(unit_seeking),
    .unit_seek_inc(unit_seek_inc), .unit_attn(unit_attn), .unit_cyl(unit_cyl)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int cyl_of(input int u);
    return int'(unit_cyl[u*CW +: CW]);
  endfunction

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // drive at a falling edge, accepting edge follows, return at next falling edge
  task automatic issue(input int u, input int f, input int c);
    start_unit = 3'(u); start_func = 3'(f); start_cyl = CW'(c); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11", "busy after reset", int'(ctrl_busy), 0);
    chk("R11", "attn after reset", int'(unit_attn), 0);
    chk("R11", "active after reset", int'(unit_active), 0);
    chk("R11", "cyl after reset", int'(unit_cyl != '0), 0);
    chk("R11", "seek_inc after reset", int'(unit_seek_inc), 0);
  endtask

  task automatic t_seek_basic();
    seek_delay = 8'd3;
    issue(2, 4, 10);
    chk("R1", "busy after accept", int'(ctrl_busy), 1);
    chk("R5", "seeking after accept", int'(unit_seeking[2]), 1);
    wait_n(1);
    chk("R2", "busy second cycle", int'(ctrl_busy), 1);
    wait_n(1);
    chk("R2", "busy released", int'(ctrl_busy), 0);
    chk("R3", "cyl at target", cyl_of(2), 10);
    wait_n(29);
    chk("R4", "attn not yet", int'(unit_attn[2]), 0);
    chk("R5", "still seeking", int'(unit_seeking[2]), 1);
    wait_n(1);
    chk("R4", "attn after 30", int'(unit_attn[2]), 1);
    chk("R4", "unit at rest", int'(unit_active[2]), 0);
    chk("R5", "seeking cleared", int'(unit_seeking[2]), 0);
  endtask

  task automatic t_zero_distance();
    issue(2, 4, 10);
    chk("R8", "attn cleared on accept", int'(unit_attn[2]), 0);
    wait_n(3);
    chk("R4", "floor not yet", int'(unit_attn[2]), 0);
    wait_n(1);
    chk("R4", "floor of 2 reached", int'(unit_attn[2]), 1);
  endtask

  task automatic t_recal();
    seek_delay = 8'd1;
    issue(2, 3, 99);
    wait_n(2);
    chk("R3", "recal cyl zero", cyl_of(2), 0);
    wait_n(9);
    chk("R4", "recal attn not yet", int'(unit_attn[2]), 0);
    wait_n(1);
    chk("R4", "recal attn at 10", int'(unit_attn[2]), 1);
  endtask

  task automatic t_idle_func();
    issue(5, 0, 50);
    chk("R5", "idle not seeking", int'(unit_seeking[5]), 0);
    chk("R1", "idle busy", int'(ctrl_busy), 1);
    wait_n(2);
    chk("R6", "idle busy released", int'(ctrl_busy), 0);
    chk("R6", "idle unit rest", int'(unit_active[5]), 0);
    wait_n(10);
    chk("R6", "idle no attn", int'(unit_attn[5]), 0);
    chk("R6", "idle cyl kept", cyl_of(5), 0);
  endtask

  task automatic t_ignore_and_overlap();
    seek_delay = 8'd3;
    issue(1, 4, 100);               // W = 300
    issue(3, 4, 20);                // during busy: ignored
    chk("R7", "start while busy keeps unit3 idle", int'(unit_active[3]), 0);
    wait_n(1);
    chk("R3", "unit1 cyl 100", cyl_of(1), 100);
    issue(1, 4, 5);                 // unit active: ignored
    chk("R7", "busy stays low on active unit", int'(ctrl_busy), 0);
    issue(4, 1, 7);                 // unsupported code
    chk("R7", "bad code no busy", int'(ctrl_busy), 0);
    chk("R7", "bad code no seeking", int'(unit_seeking[4]), 0);
    issue(6, 4, 4);                 // W = 12
    wait_n(2);
    chk("R7", "unit1 cyl unchanged", cyl_of(1), 100);
    chk("R7", "unit3 never moved", cyl_of(3), 0);
    wait_n(12);
    chk("R9", "unit6 attn while unit1 moves", int'(unit_attn[6]), 1);
    chk("R9", "unit1 still seeking", int'(unit_seeking[1]), 1);
    chk("R9", "unit1 no attn yet", int'(unit_attn[1]), 0);
  endtask

  task automatic t_seek_incomplete();
    seek_delay = 8'd1;
    issue(7, 4, 210);               // W = 210
    wait_n(2);
    chk("R10", "no inc while moving", int'(unit_seek_inc[7]), 0);
    wait_n(210);
    chk("R4", "unit7 attn", int'(unit_attn[7]), 1);
    chk("R10", "inc at rest beyond end", int'(unit_seek_inc[7]), 1);
    chk("R10", "in-range unit no inc", int'(unit_seek_inc[6]), 0);
  endtask

  task automatic t_finish_long();
    wait_n(300);
    chk("R9", "unit1 attn eventually", int'(unit_attn[1]), 1);
    issue(1, 3, 0);
    chk("R8", "unit1 attn cleared", int'(unit_attn[1]), 0);
    rst = 1'b1;
    wait_n(2);
    rst = 1'b0;
    chk("R11", "reset clears attn", int'(unit_attn), 0);
    chk("R11", "reset clears cyl", int'(unit_cyl != '0), 0);
    chk("R11", "reset clears active", int'(unit_active), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    t_reset();
    t_seek_basic();
    t_zero_distance();
    t_recal();
    t_idle_func();
    t_ignore_and_overlap();
    t_seek_incomplete();
    t_finish_long();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule